// File: doc/BRIEF.md
# Dual Capture/Compare Timer

This block is a timer built around a free-running counter that advances once every four system clocks. Two capture channels each record the counter value when a chosen transition appears on their input pin. Two compare channels each hold a 16-bit target value. When the counter steps onto that value, the channel raises a flag and applies a chosen action to its output pin.

Software reaches every register through an 8-bit bus with combinational reads. Each 16-bit quantity appears as a high byte and a low byte. A split access is kept coherent by a per-function hold that begins when the high byte is touched and ends when the low byte is touched. Five event flags, one enable for each flag and a single interrupt output complete the block.

The counter width is a parameter (`CNT_W`, 1 to 16, default 16). Counter values appear zero-extended in every 16-bit register.

Top module: `cc_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, capture registers, flags, enables and both edge/action fields read 0. Both compare registers read 0xFFFF, both output pins are low and `irq` is low.
- R2: The prescaler runs from reset. The counter steps by one on every fourth clock and wraps from all-ones to zero, so after N post-reset clock edges it holds N/4 modulo 2^CNT_W.
- R3: Reading the counter high byte (address 0x0) latches the current low byte. The next read of the counter low byte (0x1) returns that latched byte and releases the latch. A low-byte read with no latch pending returns the live low byte.
- R4: The edge field of capture channel k is bits [2k+1:2k] of the edge register at 0xA: 00 off, 01 rising, 10 falling, 11 both. A selected transition on the synchronized pin stores the counter into that channel's capture register (0x2/0x3 for channel 0, 0x4/0x5 for channel 1, high byte first) three clocks after the pin changes. It also sets the capture flag. Unselected transitions have no effect.
- R5: From a read of a capture high byte until the read of its low byte, new capture events on that channel are discarded: the register keeps its value and the flag stays clear.
- R6: Compare channel k (registers 0x6/0x7 for channel 0, 0x8/0x9 for channel 1, high byte first) matches on the clock at which the counter steps onto its value. A match sets the compare flag and applies the action in bits [2k+1:2k] of the action register at 0xB: 00 none, 01 toggle, 10 drive low, 11 drive high.
- R7: Writing a compare high byte suspends matching on that channel until its low byte is written.
- R8: The counter stepping from all-ones to zero sets the overflow flag.
- R9: The flag register at 0xC holds bits 0/1 for capture channels 0/1, bits 2/3 for compare channels 0/1 and bit 4 for overflow. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new event in the same cycle as a clear wins.
- R10: `irq` is high while any flag has its enable bit set in the register at 0xD, which uses the same bit positions as the flags.
- R11: The edge, action and enable registers read back what was written, masked to their 4, 4 and 5 implemented bits. Unmapped addresses and idle reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| cap_in | input | 2 | Capture pins, one per channel |
| cmp_out | output | 2 | Compare pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
Capture is driven with single rising edges on a rising-only channel, with falling edges that channel must ignore, and with both transitions on a both-edges channel. This separates a decoder that ignores the edge field from one that swaps the edge bits. Compare is run with each of the four pin actions on the two channels at once, with the match timed to the exact clock, so an off-by-one in the match point or a swapped action code shows up on the pins. Split accesses are exercised by delaying the low-byte read of the counter, by locking a capture channel and then firing an edge, and by writing only a compare high byte ahead of a value the counter passes. Each case shows whether the hold is honoured and released.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cap_in,
  output logic [1:0] cmp_out,
  output logic       irq
);
  localparam int PRE_W = 2;
  localparam int NCH   = 2;
  localparam int NFLG  = 2 * NCH + 1;
  localparam logic [3:0] A_CNT_HI = 4'h0;
  localparam logic [3:0] A_CNT_LO = 4'h1;
  localparam logic [3:0] A_CAP_HI = 4'h2;
  localparam logic [3:0] A_CMP_HI = 4'h6;
  localparam logic [3:0] A_EDGE   = 4'hA;
  localparam logic [3:0] A_ACT    = 4'hB;
  localparam logic [3:0] A_FLAG   = 4'hC;
  localparam logic [3:0] A_IEN    = 4'hD;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic [15:0]      cnt16;
  logic             tick, ovf_evt;
  logic [7:0]       lo_hold;
  logic             lo_held;
  logic [NCH-1:0]   s1, s2, s3;
  logic [NCH-1:0][15:0] cap_q, cmp_q;
  logic [NCH-1:0]   cap_lock, cmp_lock, cap_take, cmp_match;
  logic [2*NCH-1:0] edge_cfg, act_cfg;
  logic [NFLG-1:0]  flags, ien, flg_set, flg_clr;

  assign tick    = &pre;
  assign cnt_inc = cnt + 1'b1;
  assign cnt16   = 16'(cnt);
  assign ovf_evt = tick && (&cnt);
  assign irq     = |(flags & ien);

  wire rd_cnt_hi = bus_rd && bus_addr == A_CNT_HI;
  wire rd_cnt_lo = bus_rd && bus_addr == A_CNT_LO;
  wire wr_flag   = bus_wr && bus_addr == A_FLAG;

  assign flg_set = {ovf_evt, cmp_match, cap_take};
  assign flg_clr = wr_flag ? bus_wdata[NFLG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      cnt      <= '0;
      lo_hold  <= '0;
      lo_held  <= 1'b0;
      s1       <= '0;
      s2       <= '0;
      s3       <= '0;
      edge_cfg <= '0;
      act_cfg  <= '0;
      flags    <= '0;
      ien      <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) cnt <= cnt_inc;
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      if (rd_cnt_hi) begin
        lo_hold <= cnt16[7:0];
        lo_held <= 1'b1;
      end else if (rd_cnt_lo) begin
        lo_held <= 1'b0;
      end
      if (bus_wr && bus_addr == A_EDGE) edge_cfg <= bus_wdata[2*NCH-1:0];
      if (bus_wr && bus_addr == A_ACT)  act_cfg  <= bus_wdata[2*NCH-1:0];
      if (bus_wr && bus_addr == A_IEN)  ien      <= bus_wdata[NFLG-1:0];
      flags <= (flags & ~flg_clr) | flg_set;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [3:0] CAP_HI = 4'(A_CAP_HI + 2 * g);
    localparam logic [3:0] CMP_HI = 4'(A_CMP_HI + 2 * g);
    logic rise, fall;
    logic [1:0] esel, asel;
    assign rise = s2[g] & ~s3[g];
    assign fall = ~s2[g] & s3[g];
    assign esel = edge_cfg[2*g +: 2];
    assign asel = act_cfg[2*g +: 2];
    assign cap_take[g]  = ((esel[0] & rise) | (esel[1] & fall)) & ~cap_lock[g];
    assign cmp_match[g] = tick && !cmp_lock[g] && (16'(cnt_inc) == cmp_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_q[g]    <= '0;
        cap_lock[g] <= 1'b0;
        cmp_q[g]    <= 16'hFFFF;
        cmp_lock[g] <= 1'b0;
        cmp_out[g]  <= 1'b0;
      end else begin
        if (cap_take[g]) cap_q[g] <= cnt16;
        if (bus_rd && bus_addr == CAP_HI)           cap_lock[g] <= 1'b1;
        else if (bus_rd && bus_addr == CAP_HI + 1)  cap_lock[g] <= 1'b0;
        if (bus_wr && bus_addr == CMP_HI) begin
          cmp_q[g][15:8] <= bus_wdata;
          cmp_lock[g]    <= 1'b1;
        end else if (bus_wr && bus_addr == CMP_HI + 1) begin
          cmp_q[g][7:0]  <= bus_wdata;
          cmp_lock[g]    <= 1'b0;
        end
        if (cmp_match[g]) begin
          case (asel)
            2'b01:   cmp_out[g] <= ~cmp_out[g];
            2'b10:   cmp_out[g] <= 1'b0;
            2'b11:   cmp_out[g] <= 1'b1;
            default: cmp_out[g] <= cmp_out[g];
          endcase
        end
      end
    end
  end

  logic [7:0] rmux;
  always_comb begin
    case (bus_addr)
      4'h0:    rmux = cnt16[15:8];
      4'h1:    rmux = lo_held ? lo_hold : cnt16[7:0];
      4'h2:    rmux = cap_q[0][15:8];
      4'h3:    rmux = cap_q[0][7:0];
      4'h4:    rmux = cap_q[1][15:8];
      4'h5:    rmux = cap_q[1][7:0];
      4'h6:    rmux = cmp_q[0][15:8];
      4'h7:    rmux = cmp_q[0][7:0];
      4'h8:    rmux = cmp_q[1][15:8];
      4'h9:    rmux = cmp_q[1][7:0];
      4'hA:    rmux = 8'(edge_cfg);
      4'hB:    rmux = 8'(act_cfg);
      4'hC:    rmux = 8'(flags);
      4'hD:    rmux = 8'(ien);
      default: rmux = 8'h00;
    endcase
  end
  assign bus_rdata = bus_rd ? rmux : 8'h00;

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic [1:0]       pre,
  input logic [CNT_W-1:0] cnt,
  input logic [4:0]       flags,
  input logic [1:0]       cap_lock,
  input logic [1:0]       cmp_lock,
  input logic [1:0]       cmp_match,
  input logic [15:0]      cap0,
  input logic [15:0]      cap1,
  input logic [1:0]       cmp_out
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ($past(pre) == 2'd3 && cnt == $past(cnt) + 1'b1));

  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(cnt)) && cnt == '0) |-> flags[4]);

  p_cap0_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lock[0] |=> $stable(cap0));

  p_cap1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lock[1] |=> $stable(cap1));

  p_cmp0_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_lock[0] |=> $stable(cmp_out[0]));

  p_pin0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_match[0] |=> $stable(cmp_out[0]));

  p_pin1_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_match[1] |=> $stable(cmp_out[1]));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(bus_wr && bus_addr == 4'hC && bus_wdata[0]));
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pre(pre), .cnt(cnt), .flags(flags),
  .cap_lock(cap_lock), .cmp_lock(cmp_lock), .cmp_match(cmp_match),
  .cap0(cap_q[0]), .cap1(cap_q[1]), .cmp_out(cmp_out)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
  localparam int CW = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cap_in = '0;
  logic [1:0] cmp_out;
  logic       irq;

  int checks = 0, errors = 0, edges = 0, rd_edges = 0;

  cc_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic logic [15:0] cval(input int e);
    return 16'((e / 4) % (1 << CW));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata; rd_edges = edges;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_until(input int e);
    while (edges < e) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pins", 16'(cmp_out), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    rd(4'hC, d); check("R1 flags", 16'(d), 16'h0);
    rd(4'h6, d); check("R1 cmp0 hi", 16'(d), 16'hFF);
    rd(4'h9, d); check("R1 cmp1 lo", 16'(d), 16'hFF);
    rd(4'h3, d); check("R1 cap0 lo", 16'(d), 16'h0);
    rd(4'hA, d); check("R1 edge cfg", 16'(d), 16'h0);
    rd(4'hE, d); check("R11 unmapped", 16'(d), 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(4'hA, 8'hF6); rd(4'hA, d); check("R11 edge rb", 16'(d), 16'h06);
    wr(4'hB, 8'h39); rd(4'hB, d); check("R11 act rb", 16'(d), 16'h09);
    wr(4'hD, 8'hFF); rd(4'hD, d); check("R11 ien rb", 16'(d), 16'h1F);
    wr(4'hD, 8'h00); wr(4'hB, 8'h00); wr(4'hA, 8'h00);
  endtask

  task automatic t_counter();
    logic [7:0] h, l;
    logic [15:0] e;
    int snap;
    repeat (37) @(negedge clk);
    rd(4'h0, h); e = cval(rd_edges);
    check("R2 count hi", 16'(h), 16'(e[15:8]));
    rd(4'h1, l);
    check("R3 latched lo", 16'(l), 16'(e[7:0]));
    rd(4'h0, h); snap = rd_edges; e = cval(snap);
    repeat (57) @(negedge clk);
    rd(4'h1, l);
    check("R3 held lo after delay", 16'(l), 16'(e[7:0]));
    rd(4'h1, l);
    check("R2 live lo", 16'(l), 16'(cval(rd_edges) & 16'hFF));
  endtask

  task automatic t_capture();
    logic [7:0] h, l, f;
    logic [15:0] e;
    int m;
    wr(4'hA, 8'h0D);
    wr(4'hC, 8'h1F);
    @(negedge clk); cap_in[0] = 1'b1; m = edges; e = cval(m + 2);
    repeat (5) @(negedge clk);
    rd(4'hC, f); check("R4 cap0 flag rise", 16'(f & 8'h01), 16'h1);
    check("R10 irq masked", 16'(irq), 16'h0);
    wr(4'hD, 8'h01);
    check("R10 irq enabled", 16'(irq), 16'h1);
    wr(4'hD, 8'h00);
    rd(4'h2, h); rd(4'h3, l);
    check("R4 cap0 value", {h, l}, e);
    wr(4'hC, 8'h1F);
    @(negedge clk); cap_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(4'hC, f); check("R4 fall ignored on rising", 16'(f & 8'h01), 16'h0);
    rd(4'h2, h); rd(4'h3, l);
    check("R4 cap0 unchanged", {h, l}, e);
    @(negedge clk); cap_in[1] = 1'b1; m = edges;
    repeat (6) @(negedge clk);
    rd(4'h4, h); rd(4'h5, l);
    check("R4 cap1 rise both", {h, l}, cval(m + 2));
    wr(4'hC, 8'h1F);
    repeat (20) @(negedge clk);
    @(negedge clk); cap_in[1] = 1'b0; m = edges;
    repeat (6) @(negedge clk);
    rd(4'hC, f); check("R4 cap1 flag fall", 16'(f & 8'h02), 16'h2);
    rd(4'h4, h); rd(4'h5, l);
    check("R4 cap1 fall both", {h, l}, cval(m + 2));
  endtask

  task automatic t_cap_lock();
    logic [7:0] h, l, f, oldlo;
    int m;
    rd(4'h3, oldlo);
    rd(4'h2, h);
    wr(4'hC, 8'h1F);
    @(negedge clk); cap_in[0] = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'hC, f); check("R5 flag blocked", 16'(f & 8'h01), 16'h0);
    rd(4'h3, l); check("R5 value kept", 16'(l), 16'(oldlo));
    @(negedge clk); cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    @(negedge clk); cap_in[0] = 1'b1; m = edges;
    repeat (6) @(negedge clk);
    rd(4'hC, f); check("R5 released flag", 16'(f & 8'h01), 16'h1);
    rd(4'h2, h); rd(4'h3, l);
    check("R5 released value", {h, l}, cval(m + 2));
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    wr(4'(6 + 2 * ch), v[15:8]);
    wr(4'(7 + 2 * ch), v[7:0]);
  endtask

  task automatic t_compare();
    logic [7:0] f;
    logic [15:0] v;
    wr(4'hB, 8'h0D);
    v = cval(edges) + 16'd8;
    set_cmp(0, v); set_cmp(1, v);
    wr(4'hC, 8'h1F);
    wait_until(4 * int'(v) - 1);
    check("R6 pins before match", 16'(cmp_out), 16'h0);
    @(negedge clk);
    check("R6 toggle and set", 16'(cmp_out), 16'h3);
    rd(4'hC, f); check("R6 compare flags", 16'(f & 8'h0C), 16'hC);
    wr(4'hB, 8'h08);
    v = cval(edges) + 16'd8;
    set_cmp(0, v); set_cmp(1, v);
    wr(4'hC, 8'h1F);
    wait_until(4 * int'(v));
    check("R6 none and clear", 16'(cmp_out), 16'h1);
    rd(4'hC, f); check("R6 flags with none", 16'(f & 8'h0C), 16'hC);
  endtask

  task automatic t_cmp_lock();
    logic [7:0] f;
    logic [15:0] v;
    wr(4'hB, 8'h01);
    v = cval(edges) + 16'd8;
    wr(4'h7, v[7:0]);
    wr(4'h6, v[15:8]);
    wr(4'hC, 8'h1F);
    wait_until(4 * int'(v) + 4);
    check("R7 pin held while locked", 16'(cmp_out[0]), 16'h1);
    rd(4'hC, f); check("R7 no flag while locked", 16'(f & 8'h04), 16'h0);
    wr(4'h7, v[7:0]);
    v = cval(edges) + 16'd8;
    set_cmp(0, v);
    wait_until(4 * int'(v));
    check("R7 match after unlock", 16'(cmp_out[0]), 16'h0);
  endtask

  task automatic t_overflow();
    logic [7:0] f;
    wr(4'hD, 8'h10);
    wr(4'hC, 8'h1F);
    wait_until(4 * (1 << CW) - 1);
    check("R8 no overflow yet", 16'(irq), 16'h0);
    @(negedge clk);
    check("R10 irq on overflow", 16'(irq), 16'h1);
    rd(4'hC, f); check("R8 overflow flag", 16'(f & 8'h10), 16'h10);
    wr(4'hC, 8'h0F);
    rd(4'hC, f); check("R9 other bits keep flag", 16'(f & 8'h10), 16'h10);
    wr(4'hC, 8'h10);
    rd(4'hC, f); check("R9 w1c clears", 16'(f & 8'h10), 16'h0);
    check("R10 irq drops", 16'(irq), 16'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_counter();
    t_capture();
    t_cap_lock();
    t_compare();
    t_cmp_lock();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule